// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block derives the timing enables for a serial port from one fast system clock, nominally 24 MHz. The clock first passes a selectable prescaler. It can divide by an integer (13), divide by the fractional ratio 13/8 (1.625), or be bypassed. A programmable 16-bit divisor then produces a tick at sixteen times the bit rate. A fixed divide-by-16 on that tick yields one enable per bit period.

Both outputs are single-cycle enables in the fast clock domain. No second clock is created. The fractional ratio comes from a phase accumulator, so its ticks are spaced one or two clocks apart. Over any 13 consecutive clocks there are always exactly 8 of them. Software drives the divisor value and pulses a load strobe whenever either divisor byte is written. The strobe restarts the divisor counter and the divide-by-16 stage at once. The divisor has no defined value after reset, so it must be programmed before the outputs are used.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after release with a divisor of 0, `tick16x` and `tick1x` are both low.
- R2: With `presc_sel` = 0 (divide by 13) and divisor N, consecutive `tick16x` pulses are exactly 13·N clocks apart.
- R3: With `presc_sel` = 1 (ratio 13/8) and divisor N, `tick16x` pulses arrive only on clocks that follow a prescaler tick. Every window of 13·N·k consecutive clocks holds exactly 8·k pulses. With N = 1, pulses are 1 or 2 clocks apart.
- R4: With `presc_sel` = 2 (prescaler bypassed) and divisor N, `tick16x` pulses are exactly N clocks apart. With N = 1, `tick16x` is high on every clock.
- R5: `presc_sel` = 3 is reserved and gives the same timing as `presc_sel` = 0.
- R6: While the divisor is 0, `tick16x` and `tick1x` stay low.
- R7: `tick1x` pulses exactly once for every 16 `tick16x` pulses. It is high on the clock after the 16th `tick16x` and never on two clocks in a row.
- R8: A `div_load` pulse sampled at clock edge E reloads the divisor counter with `divisor` and clears the divide-by-16 stage. No pulse appears on the clock after E. The first `tick16x` appears N prescaler ticks after E. With the prescaler bypassed, that is N clocks after E and the first `tick1x` comes 16·N+1 clocks after E. This holds even when the load interrupts a count in progress.
- R9: A change of `divisor` without `div_load` takes effect only at the next terminal count. The interval in progress completes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock (24 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel | input | 2 | Prescaler select: 0 = /13, 1 = /1.625, 2 = bypass, 3 = reserved (/13) |
| divisor | input | 16 | Programmed divisor, 1 to 65535; 0 stops the outputs |
| div_load | input | 1 | One-clock strobe: a divisor byte was written; restart counting |
| tick16x | output | 1 | One-clock enable at 16 times the bit rate |
| tick1x | output | 1 | One-clock enable at the bit rate |

## Verification
The fractional prescaler is the hardest part to observe from the ports. Its tick pattern is never visible directly and its phase is not reset by a load. The stimulus therefore selects the 13/8 ratio and lets the accumulator settle. It then counts `tick16x` over windows whose length is a whole multiple of the accumulator period, so the expected count does not depend on phase. The load-restart timing is pinned down with the bypassed prescaler, where latency in clocks equals latency in prescaler ticks. A second load is issued partway through a count to show that the pending interval is discarded.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   typedef enum logic [1:0] {
      PS_INT    = 2'd0,
      PS_FRAC   = 2'd1,
      PS_BYPASS = 2'd2,
      PS_RSVD   = 2'd3
   } presc_e;

   typedef enum logic [1:0] {
      PM_INT,
      PM_FRAC,
      PM_BYPASS
   } presc_mode_e;

   function automatic presc_mode_e decode_presc(input logic [1:0] sel);
      case (presc_e'(sel))
         PS_FRAC:   return PM_FRAC;
         PS_BYPASS: return PM_BYPASS;
         default:   return PM_INT;
      endcase
   endfunction

endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler
   import baud_gen_pkg::*;
#(
   parameter int unsigned PRE_INT  = 13,
   parameter int unsigned FRAC_NUM = 8,
   parameter int unsigned FRAC_DEN = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] presc_sel,
   output logic       pre_tick
);

   localparam int unsigned PW = (PRE_INT > 1) ? $clog2(PRE_INT) : 1;
   localparam int unsigned AW = $clog2(FRAC_NUM + FRAC_DEN + 1);
   localparam logic [AW-1:0] NUM_C = AW'(FRAC_NUM);
   localparam logic [AW-1:0] DEN_C = AW'(FRAC_DEN);

   presc_mode_e mode;
   logic        int_tick;
   logic        frac_tick;

   assign mode = decode_presc(presc_sel);

   // integer stage: free-running modulo counter
   generate
      if (PRE_INT > 1) begin : g_int_cnt
         localparam logic [PW-1:0] LAST = PW'(PRE_INT - 1);
         logic [PW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + PW'(1);
            end
         end
         assign int_tick = (cnt_q == LAST);
      end else begin : g_int_pass
         assign int_tick = 1'b1;
      end
   endgenerate

   // fractional stage: phase accumulator, FRAC_NUM ticks per FRAC_DEN clocks
   logic [AW-1:0] acc_q;
   logic [AW-1:0] acc_sum;

   assign acc_sum   = acc_q + NUM_C;
   assign frac_tick = (acc_sum >= DEN_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (frac_tick) begin
         acc_q <= acc_sum - DEN_C;
      end else begin
         acc_q <= acc_sum;
      end
   end

   always_comb begin
      case (mode)
         PM_FRAC:   pre_tick = frac_tick;
         PM_BYPASS: pre_tick = 1'b1;
         default:   pre_tick = int_tick;
      endcase
   end

endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_tick,
   input  logic [DIV_W-1:0] divisor,
   input  logic             div_load,
   output logic             tick_out
);

   logic [DIV_W-1:0] cnt_q;
   logic             div_zero;
   logic             terminal;

   assign div_zero = (divisor == '0);
   assign terminal = (cnt_q <= DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         tick_out <= 1'b0;
      end else begin
         tick_out <= 1'b0;
         if (div_load) begin
            cnt_q <= divisor;
         end else if (pre_tick && !div_zero) begin
            if (terminal) begin
               cnt_q    <= divisor;
               tick_out <= 1'b1;
            end else begin
               cnt_q <= cnt_q - DIV_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/bg_oversample_div.sv
module bg_oversample_div #(
   parameter int unsigned RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   input  logic restart,
   output logic tick_out
);

   localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         tick_out <= 1'b0;
      end else if (restart) begin
         cnt_q    <= '0;
         tick_out <= 1'b0;
      end else begin
         tick_out <= tick_in && (cnt_q == LAST);
         if (tick_in) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned PRE_INT    = 13,
   parameter int unsigned FRAC_NUM   = 8,
   parameter int unsigned FRAC_DEN   = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       presc_sel,
   input  logic [DIV_W-1:0] divisor,
   input  logic             div_load,
   output logic             tick16x,
   output logic             tick1x
);

   generate
      if (DIV_W < 2) begin : g_bad_divw
         $error("DIV_W must be at least 2");
      end
      if (OVERSAMPLE < 2 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two, at least 2");
      end
      if (FRAC_NUM == 0 || FRAC_NUM >= FRAC_DEN) begin : g_bad_frac
         $error("FRAC_NUM must lie in 1..FRAC_DEN-1");
      end
      if (PRE_INT == 0) begin : g_bad_int
         $error("PRE_INT must be nonzero");
      end
   endgenerate

   logic pre_tick;

   bg_prescaler #(
      .PRE_INT  (PRE_INT),
      .FRAC_NUM (FRAC_NUM),
      .FRAC_DEN (FRAC_DEN)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .presc_sel (presc_sel),
      .pre_tick  (pre_tick)
   );

   bg_divider #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre_tick (pre_tick),
      .divisor  (divisor),
      .div_load (div_load),
      .tick_out (tick16x)
   );

   bg_oversample_div #(
      .RATIO (OVERSAMPLE)
   ) u_os (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (tick16x),
      .restart  (div_load),
      .tick_out (tick1x)
   );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] divisor,
   input logic             div_load,
   input logic             pre_tick,
   input logic             tick16x,
   input logic             tick1x
);

   // R6: a pulse only follows a clock where the divisor was nonzero
   p_zero_div_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick16x |-> ($past(divisor) != '0));

   // R8: the clock after a load carries no pulse on either output
   p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(div_load) |-> (!tick16x && !tick1x));

   // R7: a bit tick always follows an oversample tick
   p_onex_after_16x_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick1x |-> $past(tick16x));

   // R7: bit ticks are never back to back
   p_onex_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick1x |=> !tick1x);

   // R3: an oversample tick is only produced on a prescaler tick
   p_tick_needs_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick16x |-> $past(pre_tick));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .divisor  (divisor),
   .div_load (div_load),
   .pre_tick (pre_tick),
   .tick16x  (tick16x),
   .tick1x   (tick1x)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

   localparam time TCLK    = 42ns;
   localparam int  TIMEOUT = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  presc_sel = 2'd0;
   logic [15:0] divisor = 16'd0;
   logic        div_load = 1'b0;
   logic        tick16x;
   logic        tick1x;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(TCLK/2) clk = ~clk;

   baud_tick_gen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .presc_sel (presc_sel),
      .divisor   (divisor),
      .div_load  (div_load),
      .tick16x   (tick16x),
      .tick1x    (tick1x)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      presc_sel = s;
      divisor   = d;
      div_load  = 1'b1;
      @(negedge clk);
      div_load  = 1'b0;
   endtask

   // clocks from the current negedge until tick16x is seen high
   task automatic wait_16x(output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!tick16x && k < TIMEOUT);
   endtask

   task automatic wait_1x(output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!tick1x && k < TIMEOUT);
   endtask

   task automatic gap_16x(output int g);
      int k;
      wait_16x(k);
      wait_16x(g);
   endtask

   task automatic count_win(input int len, output int c16, output int c1);
      c16 = 0;
      c1  = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (tick16x) c16++;
         if (tick1x)  c1++;
      end
   endtask

   task automatic t_reset;
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (tick16x || tick1x) bad++;
      end
      check(bad == 0, "R1 outputs during reset", bad, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tick16x && !tick1x, "R1 first clock after release", int'(tick16x) + int'(tick1x), 0);
   endtask

   task automatic t_int13;
      int g;
      do_load(2'd0, 16'd3);
      gap_16x(g);
      check(g == 39, "R2 /13 divisor 3 spacing", g, 39);
      do_load(2'd0, 16'd1);
      gap_16x(g);
      check(g == 13, "R2 /13 divisor 1 spacing", g, 13);
   endtask

   task automatic t_reserved;
      int g;
      do_load(2'd3, 16'd2);
      gap_16x(g);
      check(g == 26, "R5 reserved select spacing", g, 26);
   endtask

   task automatic t_frac;
      int c16, c1, k, g, gmax;
      do_load(2'd1, 16'd1);
      count_win(20, c16, c1);
      count_win(130, c16, c1);
      check(c16 == 80, "R3 13/8 divisor 1 count in 130 clocks", c16, 80);
      gmax = 0;
      wait_16x(k);
      for (int i = 0; i < 20; i++) begin
         wait_16x(g);
         if (g > gmax) gmax = g;
      end
      check(gmax == 2, "R3 13/8 divisor 1 largest spacing", gmax, 2);
      do_load(2'd1, 16'd3);
      count_win(50, c16, c1);
      count_win(156, c16, c1);
      check(c16 == 32, "R3 13/8 divisor 3 count in 156 clocks", c16, 32);
   endtask

   task automatic t_bypass;
      int g, c16, c1;
      do_load(2'd2, 16'd7);
      gap_16x(g);
      check(g == 7, "R4 bypass divisor 7 spacing", g, 7);
      do_load(2'd2, 16'd1);
      count_win(2, c16, c1);
      count_win(50, c16, c1);
      check(c16 == 50, "R4 bypass divisor 1 continuous", c16, 50);
   endtask

   task automatic t_zero;
      int c16, c1;
      do_load(2'd2, 16'd0);
      count_win(2000, c16, c1);
      check(c16 == 0, "R6 divisor 0 tick16x", c16, 0);
      check(c1 == 0, "R6 divisor 0 tick1x", c1, 0);
   endtask

   task automatic t_onex;
      int c16, c1, k;
      do_load(2'd2, 16'd2);
      wait_1x(k);
      count_win(320, c16, c1);
      check(c1 == 10, "R7 tick1x count in 320 clocks", c1, 10);
      check(c16 == 160, "R7 tick16x count in 320 clocks", c16, 160);
   endtask

   task automatic t_load;
      int k;
      do_load(2'd2, 16'd5);
      wait_16x(k);
      check(k == 5, "R8 load to first tick16x", k, 5);
      do_load(2'd2, 16'd5);
      wait_1x(k);
      check(k == 81, "R8 load to first tick1x", k, 81);
      do_load(2'd2, 16'd10);
      repeat (6) @(negedge clk);
      do_load(2'd2, 16'd10);
      wait_16x(k);
      check(k == 10, "R8 reload during count", k, 10);
   endtask

   task automatic t_nolaod_change;
      int k, g1, g2;
      do_load(2'd2, 16'd4);
      wait_16x(k);
      divisor = 16'd9;
      wait_16x(g1);
      check(g1 == 4, "R9 interval in progress keeps old divisor", g1, 4);
      wait_16x(g2);
      check(g2 == 9, "R9 next interval uses new divisor", g2, 9);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(TCLK * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_int13();
      t_reserved();
      t_frac();
      t_bypass();
      t_zero();
      t_onex();
      t_load();
      t_nolaod_change();
      finish_run();
   end

endmodule